// File: doc/BRIEF.md
# Dual-Socket Interrupt Mode Controller

This block holds a single global control register that both card sockets share, together with the logic that register steers. The register sets four things. It chooses edge or level signalling for each socket's functional interrupt. It chooses edge or level signalling for the card-status-change interrupt. It chooses whether status-change flags clear when software reads them or when software writes 1s back. It also enables a power-down mode that keeps the card-side output enables off except while a card access is in progress.

A simple register bus reaches the block. The bus has an address, separate read and write strobes, write data and combinational read data. The control register is visible at two aliased addresses, one in each socket's window: 1Eh for socket A and 5Eh for socket B. The status-change flag register is visible at 04h and 44h.

Status-change events arrive as single-cycle strobes and set flags. The block turns the flags and the two card interrupt request lines into registered host interrupt outputs.

Top module: `irq_mode_ctrl`

## Requirements
- R1: After the global reset `rst_n` the control register reads 00h, all status flags read 0, both host interrupts and the status-change interrupt are 0, and both card output enables are 1.
- R2: Control register bit layout: bit 4 is the socket B interrupt mode, bit 3 is the socket A interrupt mode (0 = edge, 1 = level), bit 2 is the flag clear method (0 = clear on read, 1 = write 1 to clear), bit 1 is the status-change interrupt mode (0 = edge, 1 = level), and bit 0 enables power-down. Bits 7 to 5 always read 0 and ignore writes.
- R3: Addresses 1Eh and 5Eh read and write the same control storage, and addresses 04h and 44h read the same status flags. A read of any other address returns 0, and read data is 0 whenever `bus_rd` is low.
- R4: `sock_rst` clears only bits 4 and 3 of the control register, on the next clock edge. Bits 2 to 0 are cleared only by `rst_n`.
- R5: In edge mode, a rising edge of `card_irq[i]` gives exactly one high cycle on `host_irq[i]`, starting one clock later. In level mode, `host_irq[i]` follows `card_irq[i]` one clock later. Index 0 is socket A and index 1 is socket B.
- R6: In edge mode, `host_csc_irq` pulses for one cycle, one clock after a flag changes from 0 to 1. An event on a flag that is already set gives no pulse. In level mode, `host_csc_irq` is high one clock after any flag is set, and it stays high while any flag remains set.
- R7: A `csc_evt[k]` strobe sets flag k, and the flag is readable at bit k of the status register. In clear-on-read mode, a status read returns the flags and then clears all of them. Writes to the status register have no effect in this mode.
- R8: In write-1-to-clear mode, a status write clears each flag whose write-data bit is 1. Status reads leave the flags unchanged in this mode.
- R9: A flag event in the same cycle as a clearing read or write-back leaves that flag set.
- R10: While power-down is 0, `card_oe` is all ones. While power-down is 1, `card_oe[i]` is 1 exactly in the cycles that follow a cycle with `card_access[i]` high, and 0 otherwise.
- R11: In power-down mode, status-change events still set flags and still raise `host_csc_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| sock_rst | input | 1 | Per-socket synchronous reset; clears the interrupt mode bits only |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, valid while bus_rd is high |
| card_irq | input | 2 | Functional interrupt requests; index 0 is socket A |
| csc_evt | input | NFLAG | Status-change event strobes |
| card_access | input | 2 | High while an access cycle runs on that socket's card interface |
| host_irq | output | 2 | Shaped host functional interrupts |
| host_csc_irq | output | 1 | Shaped host status-change interrupt |
| card_oe | output | 2 | Card-side output enables |

## Verification
A status-change event can arrive in the same cycle as the bus access that clears the flags. That access is a status read in clear-on-read mode, or a write-back in write-1-to-clear mode. Directed sequences force this collision in both clear modes, and sparse random event strobes mixed with random status reads and writes produce it again many times. Each collision is judged from the port side: the following status read must still show the colliding flag, and the status-change interrupt must match a cycle model in the bench.

// File: rtl/irq_mode_pkg.sv
`timescale 1ns/1ps
package irq_mode_pkg;
    localparam int NSOCK = 2;

    // Field order matches the register bit order: the first field is bit 4.
    typedef struct packed {
        logic mode_b;
        logic mode_a;
        logic clr_w1c;
        logic csc_level;
        logic pwrdn;
    } gctl_t;

    localparam int CTL_W = $bits(gctl_t);
    localparam gctl_t GCTL_RST = '0;
endpackage

// File: rtl/irq_ctrl_reg.sv
`timescale 1ns/1ps
module irq_ctrl_reg
    import irq_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sock_rst,
    input  logic             wr_hit,
    input  logic [CTL_W-1:0] wdata,
    output gctl_t            ctrl_o
);
    typedef struct packed {
        gctl_t ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.ctrl = gctl_t'(wdata);
        end
        // the per-socket reset reaches the interrupt mode bits only
        if (sock_rst) begin
            st_d.ctrl.mode_b = 1'b0;
            st_d.ctrl.mode_a = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= GCTL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic             w1c,
    input  logic [NFLAG-1:0] wmask,
    output logic [NFLAG-1:0] flags_o,
    output logic [NFLAG-1:0] newset_o
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } st_t;

    st_t              st_d, st_q;
    logic [NFLAG-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (!w1c && rd_hit) begin
            clr = '1;
        end
        if (w1c && wr_hit) begin
            clr = wmask;
        end
        // an incoming event is applied after the clear, so it is never lost
        st_d.flags = (st_q.flags & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o  = st_q.flags;
    assign newset_o = evt & ~st_q.flags;
endmodule

// File: rtl/irq_shaper.sv
`timescale 1ns/1ps
module irq_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic lvl_src,
    input  logic pulse_src,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = level_mode ? lvl_src : pulse_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_mode_ctrl.sv
`timescale 1ns/1ps
module irq_mode_ctrl
    import irq_mode_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NFLAG   = 4,
    parameter int BASE_A  = 'h00,
    parameter int BASE_B  = 'h40,
    parameter int CTL_OFS = 'h1E,
    parameter int STS_OFS = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sock_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSOCK-1:0]  card_irq,
    input  logic [NFLAG-1:0]  csc_evt,
    input  logic [NSOCK-1:0]  card_access,
    output logic [NSOCK-1:0]  host_irq,
    output logic              host_csc_irq,
    output logic [NSOCK-1:0]  card_oe
);
    localparam logic [ADDR_W-1:0] CTL_ADDR_A = ADDR_W'(BASE_A + CTL_OFS);
    localparam logic [ADDR_W-1:0] CTL_ADDR_B = ADDR_W'(BASE_B + CTL_OFS);
    localparam logic [ADDR_W-1:0] STS_ADDR_A = ADDR_W'(BASE_A + STS_OFS);
    localparam logic [ADDR_W-1:0] STS_ADDR_B = ADDR_W'(BASE_B + STS_OFS);

    typedef struct packed {
        logic [NSOCK-1:0] prev;
        logic [NSOCK-1:0] oe;
    } top_st_t;

    gctl_t            ctrl;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] newset;
    logic [NSOCK-1:0] smode;
    logic             ctl_hit;
    logic             sts_hit;
    logic             unused_wbits;
    top_st_t          st_d, st_q;

    assign ctl_hit      = (bus_addr == CTL_ADDR_A) || (bus_addr == CTL_ADDR_B);
    assign sts_hit      = (bus_addr == STS_ADDR_A) || (bus_addr == STS_ADDR_B);
    assign unused_wbits = ^bus_wdata[DATA_W-1:CTL_W];
    assign smode        = {ctrl.mode_b, ctrl.mode_a};

    irq_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sock_rst (sock_rst),
        .wr_hit   (bus_wr && ctl_hit),
        .wdata    (bus_wdata[CTL_W-1:0]),
        .ctrl_o   (ctrl)
    );

    irq_flag_bank #(.NFLAG(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (csc_evt),
        .rd_hit   (bus_rd && sts_hit),
        .wr_hit   (bus_wr && sts_hit),
        .w1c      (ctrl.clr_w1c),
        .wmask    (bus_wdata[NFLAG-1:0]),
        .flags_o  (flags),
        .newset_o (newset)
    );

    for (genvar s = 0; s < NSOCK; s++) begin : g_fn
        irq_shaper u_fn (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (smode[s]),
            .lvl_src    (card_irq[s]),
            .pulse_src  (card_irq[s] & ~st_q.prev[s]),
            .irq_o      (host_irq[s])
        );
    end

    irq_shaper u_csc (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (ctrl.csc_level),
        .lvl_src    (|flags),
        .pulse_src  (|newset),
        .irq_o      (host_csc_irq)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = card_irq;
        st_d.oe   = {NSOCK{~ctrl.pwrdn}} | card_access;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '0;
            st_q.oe   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_oe = st_q.oe;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && ctl_hit) begin
            bus_rdata[CTL_W-1:0] = ctrl;
        end else if (bus_rd && sts_hit) begin
            bus_rdata[NFLAG-1:0] = flags;
        end
    end
endmodule

// File: rtl/irq_mode_ctrl_chk.sv
`timescale 1ns/1ps
module irq_mode_ctrl_chk
    import irq_mode_pkg::*;
#(
    parameter int NFLAG = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sock_rst,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [NFLAG-1:0] csc_evt,
    input logic [NSOCK-1:0] card_access,
    input gctl_t            ctrl,
    input logic [NFLAG-1:0] flags,
    input logic [NSOCK-1:0] host_irq,
    input logic             host_csc_irq,
    input logic [NSOCK-1:0] card_oe
);
    AST_SOCK_RST_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        sock_rst |=> (!ctrl.mode_a && !ctrl.mode_b)); // R4

    AST_EDGE_SINGLE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq[0] && !ctrl.mode_a) |=> !host_irq[0]); // R5

    AST_CSC_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.csc_level && (|flags)) |=> host_csc_irq); // R6

    AST_W1C_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.clr_w1c && bus_rd && !bus_wr && !(|csc_evt)) |=> $stable(flags)); // R8

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|csc_evt) |=> ((flags & $past(csc_evt)) == $past(csc_evt))); // R9

    AST_OE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.pwrdn |=> (&card_oe)); // R10

    AST_OE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        card_access[0] |=> card_oe[0]); // R10
endmodule

bind irq_mode_ctrl irq_mode_ctrl_chk #(.NFLAG(NFLAG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sock_rst     (sock_rst),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .csc_evt      (csc_evt),
    .card_access  (card_access),
    .ctrl         (ctrl),
    .flags        (flags),
    .host_irq     (host_irq),
    .host_csc_irq (host_csc_irq),
    .card_oe      (card_oe)
);

// File: tb/irq_mode_ctrl_test.sv
`timescale 1ns/1ps
module irq_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sock_rst = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] card_irq = '0;
    logic [3:0] csc_evt = '0;
    logic [1:0] card_access = '0;
    logic [1:0] host_irq;
    logic       host_csc_irq;
    logic [1:0] card_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [7:0] rd_val;

    // bench cycle model, written from the requirements
    logic [4:0] m_ctrl;
    logic [3:0] m_flags;
    logic [1:0] m_prev;
    logic [1:0] m_irq;
    logic       m_csc;
    logic [1:0] m_oe;

    always #2.5 clk = ~clk;

    irq_mode_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sock_rst     (sock_rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .card_irq     (card_irq),
        .csc_evt      (csc_evt),
        .card_access  (card_access),
        .host_irq     (host_irq),
        .host_csc_irq (host_csc_irq),
        .card_oe      (card_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic is_ctl(input logic [7:0] a);
        return (a == 8'h1E) || (a == 8'h5E);
    endfunction

    function automatic logic is_sts(input logic [7:0] a);
        return (a == 8'h04) || (a == 8'h44);
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!bus_rd) return 8'h00;
        if (is_ctl(bus_addr)) return {3'b000, m_ctrl};
        if (is_sts(bus_addr)) return {4'b0000, m_flags};
        return 8'h00;
    endfunction

    task automatic model_tick();
        logic [3:0] clr;
        for (int i = 0; i < 2; i++) begin
            m_irq[i] = m_ctrl[3+i] ? card_irq[i] : (card_irq[i] & ~m_prev[i]);
        end
        m_csc  = m_ctrl[1] ? (|m_flags) : (|(csc_evt & ~m_flags));
        m_oe   = {2{~m_ctrl[0]}} | card_access;
        m_prev = card_irq;
        clr = 4'h0;
        if (bus_rd && is_sts(bus_addr) && !m_ctrl[2]) clr = 4'hF;
        if (bus_wr && is_sts(bus_addr) && m_ctrl[2]) clr = bus_wdata[3:0];
        m_flags = (m_flags & ~clr) | csc_evt;
        if (bus_wr && is_ctl(bus_addr)) m_ctrl = bus_wdata[4:0];
        if (sock_rst) m_ctrl[4:3] = 2'b00;
    endtask

    task automatic cyc();
        #1;
        if (bus_rd) begin
            rd_val = bus_rdata;
            chk("R3 read data", bus_rdata, exp_rdata());
        end
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("R5 host_irq", host_irq, m_irq);
        chk("R6 host_csc_irq", host_csc_irq, m_csc);
        chk("R10 card_oe", card_oe, m_oe);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        csc_evt = '0;
        sock_rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        cyc();
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        bus_rd = 1'b1;
        cyc();
    endtask

    task automatic evt(input logic [3:0] e);
        csc_evt = e;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_ctrl = '0; m_flags = '0; m_prev = '0; m_irq = '0; m_csc = 1'b0; m_oe = 2'b11;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 host_irq", host_irq, 2'b00);
        chk("R1 host_csc_irq", host_csc_irq, 1'b0);
        chk("R1 card_oe", card_oe, 2'b11);
        rd(8'h1E); chk("R1 ctrl", rd_val, 8'h00);
        rd(8'h04); chk("R1 flags", rd_val, 8'h00);

        // R2 reserved bits, R3 aliasing
        wr(8'h1E, 8'hFF);
        rd(8'h1E); chk("R2 reserved bits", rd_val, 8'h1F);
        rd(8'h5E); chk("R3 alias read", rd_val, 8'h1F);
        wr(8'h5E, 8'h0A);
        rd(8'h1E); chk("R3 alias write", rd_val, 8'h0A);
        rd(8'h33); chk("R3 unmapped", rd_val, 8'h00);

        // R4 socket reset
        wr(8'h1E, 8'h1F);
        sock_rst = 1'b1; cyc();
        rd(8'h5E); chk("R4 sock_rst", rd_val, 8'h07);

        // R7 clear on read
        wr(8'h1E, 8'h00);
        evt(4'b0101);
        rd(8'h04); chk("R7 flags", rd_val, 8'h05);
        rd(8'h44); chk("R7 cleared", rd_val, 8'h00);
        evt(4'b0010);
        wr(8'h04, 8'h0F);
        rd(8'h04); chk("R7 write ignored", rd_val, 8'h02);

        // R8 write 1 to clear
        wr(8'h1E, 8'h04);
        evt(4'b0011);
        rd(8'h04); chk("R8 flags", rd_val, 8'h03);
        rd(8'h04); chk("R8 read quiet", rd_val, 8'h03);
        wr(8'h44, 8'h01);
        rd(8'h04); chk("R8 partial clear", rd_val, 8'h02);
        wr(8'h04, 8'h02);
        rd(8'h04); chk("R8 all clear", rd_val, 8'h00);

        // R9 collisions in both clear modes
        evt(4'b0001);
        bus_addr = 8'h04; bus_wdata = 8'h01; bus_wr = 1'b1; csc_evt = 4'b0001; cyc();
        rd(8'h04); chk("R9 w1c collision", rd_val, 8'h01);
        wr(8'h04, 8'h01);
        wr(8'h1E, 8'h00);
        evt(4'b0001);
        bus_addr = 8'h04; bus_rd = 1'b1; csc_evt = 4'b0001; cyc();
        chk("R9 read value", rd_val, 8'h01);
        rd(8'h04); chk("R9 read collision", rd_val, 8'h01);

        // R5 functional interrupt shaping
        card_irq = 2'b01; cyc(); chk("R5 edge pulse", host_irq, 2'b01);
        cyc(); chk("R5 edge single", host_irq, 2'b00);
        card_irq = 2'b00; cyc();
        wr(8'h1E, 8'h08);
        card_irq = 2'b01; cyc(); chk("R5 level A", host_irq, 2'b01);
        cyc(); chk("R5 level A held", host_irq, 2'b01);
        card_irq = 2'b00; cyc(); chk("R5 level A drop", host_irq, 2'b00);
        wr(8'h1E, 8'h10);
        card_irq = 2'b10; cyc(); chk("R5 level B", host_irq, 2'b10);
        cyc(); chk("R5 level B held", host_irq, 2'b10);
        card_irq = 2'b00; cyc(); chk("R5 level B drop", host_irq, 2'b00);

        // R6 status-change interrupt shaping
        wr(8'h1E, 8'h00);
        evt(4'b0100); chk("R6 edge pulse", host_csc_irq, 1'b1);
        cyc(); chk("R6 edge single", host_csc_irq, 1'b0);
        evt(4'b0100); chk("R6 already set", host_csc_irq, 1'b0);
        rd(8'h04);
        wr(8'h1E, 8'h02);
        evt(4'b0001); chk("R6 level lag", host_csc_irq, 1'b0);
        cyc(); chk("R6 level high", host_csc_irq, 1'b1);
        cyc(); chk("R6 level held", host_csc_irq, 1'b1);
        rd(8'h04); chk("R6 level before clear", host_csc_irq, 1'b1);
        cyc(); chk("R6 level drop", host_csc_irq, 1'b0);

        // R10 power-down gating, R11 events during power-down
        wr(8'h1E, 8'h01); chk("R10 oe before", card_oe, 2'b11);
        cyc(); chk("R10 oe off", card_oe, 2'b00);
        card_access = 2'b01; cyc(); chk("R10 oe wake", card_oe, 2'b01);
        cyc(); chk("R10 oe held", card_oe, 2'b01);
        card_access = 2'b00; cyc(); chk("R10 oe sleep", card_oe, 2'b00);
        evt(4'b1000); chk("R11 csc pulse", host_csc_irq, 1'b1);
        rd(8'h04); chk("R11 flag", rd_val, 8'h08);
        wr(8'h1E, 8'h00);
        cyc(); chk("R10 oe restored", card_oe, 2'b11);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            pick = $urandom % 6;
            case (pick)
                0: bus_addr = 8'h1E;
                1: bus_addr = 8'h5E;
                2, 5: bus_addr = 8'h04;
                3: bus_addr = 8'h44;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata = 8'($urandom);
            pick = $urandom % 4;
            bus_rd = (pick == 0);
            bus_wr = (pick == 1);
            if ($urandom % 4 == 0) card_irq = card_irq ^ 2'($urandom);
            csc_evt = ($urandom % 4 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
            card_access = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            sock_rst = ($urandom % 40 == 0);
            cyc();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule